// File: doc/BRIEF.md
# Indirect PHY Register Access Bridge

This block lets a host that only sees a flat space of 16-bit registers reach the management registers of the internal per-port PHYs. The host loads a target address and, for writes, a data word into two holding registers. It then writes a control word whose low bit starts the transfer. The bridge carries out one request/acknowledge exchange on the PHY side. While the exchange runs, the start bit reads back as a busy flag, and the bit clears by itself when the exchange is over. On a read, the word the PHY returns is placed in the data holding register.

The host may start transfers only while two enables agree: an access-enable bit in a special control register must be set, and a PHY-block bit in a global control register must be clear. The target address carries a port field. A port without an internal PHY never gets a request on the PHY side. A read to such a port returns all ones. A write to such a port raises an error flag. A PHY that never acknowledges is abandoned after a fixed number of cycles.

Top module: `phy_ind_bridge`

## Requirements
- R1: After a synchronous active-low reset, every host-visible register reads 0x0000 and `phy_req` is 0.
- R2: Register map. The indirect address is at 0x075C (16 bits) and the indirect data at 0x0760 (16 bits). The control word at 0x0768 has the error flag at bit 15, the direction of the last accepted start at bit 1 and busy at bit 0. The special control register at 0x077C keeps bits 15..12 and 9..8. The global control register at 0x0007 keeps bit 7. Bits that are not kept read 0, and unmapped addresses read 0x0000.
- R3: Writing 1 to control bit 0 starts a transfer only when special-control bit 12 is 1 and global-control bit 7 is 0. In any other case busy stays 0 and no request is made.
- R4: In a write start (control bits 1 and 0 both 1), busy and `phy_req` rise in the cycle after the host write, with `phy_we`=1, `phy_addr` equal to the address register and `phy_wdata` equal to the data register. They hold until `phy_ack`, and busy reads 0 in the cycle after the acknowledge.
- R5: A read start (bit 1 = 0, bit 0 = 1) to a present PHY drives `phy_we`=0. The `phy_rdata` value seen with `phy_ack` appears in the data register once busy has cleared.
- R6: Address bits 15..12 form a port field f. The PHY is present only when 1 ≤ f ≤ NUM_PORTS and PHY_MASK[f-1] = 1. A read to an absent PHY makes no request, leaves busy at 0, and the data register reads 0xFFFF in the next cycle.
- R7: A write to an absent PHY makes no request, leaves busy at 0, sets the error flag (control reads 0x8002), and leaves the data register unchanged.
- R8: While busy is 1, host writes to the address, data and control registers are ignored.
- R9: If no acknowledge arrives within TIMEOUT (default 1024) request cycles, busy clears and the error flag sets. For a read, the data register also becomes 0xFFFF.
- R10: Every accepted start clears the error flag.
- R11: An acknowledge that arrives while no transfer is running changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 16 | Host register address (read and write) |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data for `host_addr` (combinational) |
| phy_req | output | 1 | PHY-side request, held until acknowledge or abort |
| phy_we | output | 1 | 1 = write, 0 = read |
| phy_addr | output | 16 | Indirect target address |
| phy_wdata | output | 16 | Data for a PHY write |
| phy_ack | input | 1 | PHY-side completion |
| phy_rdata | input | 16 | PHY read data, valid with `phy_ack` |

## Verification
The main transfer is exercised in random rounds. Each round picks a random port field, a random register number, a random direction and a random acknowledge delay, so present and absent ports are mixed with reads and writes. The random rounds show whether the port decode and the direction each steer the right path: request, all-ones return, or error. Directed cases cover the edges of the port field (0, the last present port, and values above NUM_PORTS), each enable closed on its own, writes made while busy, a PHY that stays silent until timeout, and a stray acknowledge.

// File: rtl/phy_bridge_pkg.sv
`timescale 1ns/1ps
// Shared constants for the indirect PHY bridge: host register addresses,
// control bit positions, kept-bit masks and the transfer state type.
package phy_bridge_pkg;
    localparam logic [15:0] A_GCTRL = 16'h0007;
    localparam logic [15:0] A_IADDR = 16'h075C;
    localparam logic [15:0] A_IDATA = 16'h0760;
    localparam logic [15:0] A_ICTRL = 16'h0768;
    localparam logic [15:0] A_SPEC  = 16'h077C;

    localparam int B_BUSY   = 0;
    localparam int B_WE     = 1;
    localparam int B_ERR    = 15;
    localparam int B_ACC_EN = 12;
    localparam int B_BLOCK  = 7;

    localparam logic [15:0] SPEC_KEEP  = 16'hF300;
    localparam logic [15:0] GCTRL_KEEP = 16'h0080;
    localparam logic [15:0] ALL_ONES   = 16'hFFFF;

    typedef enum logic {XF_IDLE, XF_WAIT} xfer_state_t;
endpackage

// File: rtl/phy_port_check.sv
`timescale 1ns/1ps
// Decides whether the port field of an indirect address names a port that
// has an internal PHY. Field value f selects port f-1; 0 never matches.
// Assumes NUM_PORTS <= 15 so every port fits the 4-bit field.
module phy_port_check #(
    parameter int                     NUM_PORTS = 8,
    parameter logic [NUM_PORTS-1:0]   PHY_MASK  = '1
) (
    input  logic [3:0] port_field,
    output logic       present
);
    logic [NUM_PORTS-1:0] hit;

    // One comparator per port, masked by whether that port has a PHY.
    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
        assign hit[i] = (port_field == 4'(i + 1)) && PHY_MASK[i];
    end

    assign present = |hit;
endmodule

// File: rtl/phy_host_regs.sv
`timescale 1ns/1ps
// Host-visible holding registers and read mux. Produces the start pulse
// when control bit 0 is written with access enabled and no transfer running.
// Assumes at most one of host write and engine capture targets data per cycle
// (capture wins).
module phy_host_regs
    import phy_bridge_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic [15:0] host_addr,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata,
    input  logic        busy,
    input  logic        err,
    input  logic        xfer_we,
    input  logic        cap_en,
    input  logic [15:0] cap_data,
    output logic [15:0] addr_q,
    output logic [15:0] data_q,
    output logic        access_en,
    output logic        start,
    output logic        start_we
);
    logic [15:0] spec_q;
    logic [15:0] gctrl_q;

    assign access_en = spec_q[B_ACC_EN] && !gctrl_q[B_BLOCK];
    assign start     = host_wr && (host_addr == A_ICTRL) && host_wdata[B_BUSY]
                       && !busy && access_en;
    assign start_we  = host_wdata[B_WE];

    // Holding registers: mailbox writes locked while busy, capture has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            data_q  <= '0;
            spec_q  <= '0;
            gctrl_q <= '0;
        end else begin
            if (host_wr && host_addr == A_IADDR && !busy) addr_q <= host_wdata;
            if (cap_en)                                   data_q <= cap_data;
            else if (host_wr && host_addr == A_IDATA && !busy) data_q <= host_wdata;
            if (host_wr && host_addr == A_SPEC)  spec_q  <= host_wdata & SPEC_KEEP;
            if (host_wr && host_addr == A_GCTRL) gctrl_q <= host_wdata & GCTRL_KEEP;
        end
    end

    // Read mux; control word shows live busy, direction and error flag.
    always_comb begin
        case (host_addr)
            A_IADDR: host_rdata = addr_q;
            A_IDATA: host_rdata = data_q;
            A_ICTRL: host_rdata = {err, 13'd0, xfer_we, busy};
            A_SPEC:  host_rdata = spec_q;
            A_GCTRL: host_rdata = gctrl_q;
            default: host_rdata = '0;
        endcase
    end
endmodule

// File: rtl/phy_xfer_engine.sv
`timescale 1ns/1ps
// Runs one PHY-side request/acknowledge exchange per start pulse, handles
// absent ports without a request, and aborts after TIMEOUT silent cycles.
// Assumes start is only pulsed while idle.
module phy_xfer_engine
    import phy_bridge_pkg::*;
#(
    parameter int TIMEOUT = 1024,
    localparam int CNT_W  = $clog2(TIMEOUT + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        start_we,
    input  logic        present,
    input  logic        phy_ack,
    input  logic [15:0] phy_rdata,
    output logic        busy,
    output logic        xfer_we,
    output logic        err,
    output logic        cap_en,
    output logic [15:0] cap_data
);
    xfer_state_t      state;
    logic [CNT_W-1:0] wait_cnt;
    logic             expired;

    assign busy    = (state == XF_WAIT);
    assign expired = (wait_cnt == CNT_W'(TIMEOUT - 1));

    // Transfer sequencing, error flag and timeout counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= XF_IDLE;
            xfer_we  <= 1'b0;
            err      <= 1'b0;
            wait_cnt <= '0;
        end else begin
            case (state)
                XF_IDLE: if (start) begin
                    xfer_we  <= start_we;
                    wait_cnt <= '0;
                    err      <= !present && start_we;
                    if (present) state <= XF_WAIT;
                end
                XF_WAIT: begin
                    if (phy_ack) begin
                        state <= XF_IDLE;
                    end else if (expired) begin
                        state <= XF_IDLE;
                        err   <= 1'b1;
                    end else begin
                        wait_cnt <= wait_cnt + 1'b1;
                    end
                end
                default: state <= XF_IDLE;
            endcase
        end
    end

    // Data capture: PHY data on read ack, all ones on absent read or abort.
    always_comb begin
        cap_en   = 1'b0;
        cap_data = ALL_ONES;
        if (state == XF_IDLE && start && !present && !start_we) begin
            cap_en = 1'b1;
        end else if (state == XF_WAIT && !xfer_we) begin
            if (phy_ack) begin
                cap_en   = 1'b1;
                cap_data = phy_rdata;
            end else if (expired) begin
                cap_en = 1'b1;
            end
        end
    end
endmodule

// File: rtl/phy_ind_bridge.sv
`timescale 1ns/1ps
// Indirect PHY register access bridge: host mailbox registers in front of
// a per-port PHY request/acknowledge bus. Assumes a single-cycle host write
// strobe and a PHY that holds phy_rdata valid with phy_ack.
module phy_ind_bridge #(
    parameter int                   NUM_PORTS = 8,
    parameter logic [NUM_PORTS-1:0] PHY_MASK  = 8'h3F,
    parameter int                   TIMEOUT   = 1024
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic [15:0] host_addr,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata,
    output logic        phy_req,
    output logic        phy_we,
    output logic [15:0] phy_addr,
    output logic [15:0] phy_wdata,
    input  logic        phy_ack,
    input  logic [15:0] phy_rdata
);
    logic        busy, err, xfer_we, cap_en, access_en, start, start_we, present;
    logic [15:0] cap_data, addr_q, data_q;

    phy_host_regs i_regs (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .busy(busy), .err(err),
        .xfer_we(xfer_we), .cap_en(cap_en), .cap_data(cap_data), .addr_q(addr_q),
        .data_q(data_q), .access_en(access_en), .start(start), .start_we(start_we)
    );

    phy_port_check #(.NUM_PORTS(NUM_PORTS), .PHY_MASK(PHY_MASK)) i_port (
        .port_field(addr_q[15:12]), .present(present)
    );

    phy_xfer_engine #(.TIMEOUT(TIMEOUT)) i_eng (
        .clk(clk), .rst_n(rst_n), .start(start), .start_we(start_we),
        .present(present), .phy_ack(phy_ack), .phy_rdata(phy_rdata),
        .busy(busy), .xfer_we(xfer_we), .err(err), .cap_en(cap_en),
        .cap_data(cap_data)
    );

    assign phy_req   = busy;
    assign phy_we    = xfer_we;
    assign phy_addr  = addr_q;
    assign phy_wdata = data_q;
endmodule

// File: rtl/phy_ind_bridge_chk.sv
`timescale 1ns/1ps
// Property checker for phy_ind_bridge, attached by bind below.
module phy_ind_bridge_chk #(
    parameter int TIMEOUT = 1024,
    localparam int CNT_W  = $clog2(TIMEOUT + 1)
) (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        err,
    input logic        access_en,
    input logic        start,
    input logic        start_we,
    input logic        present,
    input logic        phy_req,
    input logic        phy_we,
    input logic        phy_ack,
    input logic [15:0] phy_addr,
    input logic [15:0] phy_wdata,
    input logic [15:0] data_q
);
    logic [CNT_W-1:0] busy_len;

    // Length of the current busy run, for the timeout bound.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) busy_len <= '0;
        else                 busy_len <= busy_len + 1'b1;
    end

    a_r3_gated_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!access_en && !busy) |=> !busy);
    a_r4_ack_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_req && phy_ack) |=> !phy_req);
    a_r6_absent_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !present) |=> !phy_req);
    a_r6_absent_read_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !present && !start_we) |=> (data_q == 16'hFFFF));
    a_r7_absent_write_err: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !present && start_we) |=> err);
    a_r8_addr_locked: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(phy_addr));
    a_r8_wdata_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && phy_we) |=> $stable(phy_wdata));
    a_r9_bounded_wait: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_len < CNT_W'(TIMEOUT)));
    a_r10_start_clears_err: assert property (@(posedge clk) disable iff (!rst_n)
        (start && present) |=> !err);
endmodule

bind phy_ind_bridge phy_ind_bridge_chk #(.TIMEOUT(TIMEOUT)) i_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .err(err), .access_en(access_en),
    .start(start), .start_we(start_we), .present(present), .phy_req(phy_req),
    .phy_we(phy_we), .phy_ack(phy_ack), .phy_addr(phy_addr),
    .phy_wdata(phy_wdata), .data_q(data_q)
);

// File: tb/test_phy_ind_bridge.sv
`timescale 1ns/1ps
module test_phy_ind_bridge;
    localparam logic [15:0] GC = 16'h0007, IA = 16'h075C, ID = 16'h0760,
                            IC = 16'h0768, SP = 16'h077C;
    localparam int TMO = 1024;

    logic clk = 1'b0, rst_n = 1'b0, host_wr = 1'b0, phy_ack = 1'b0;
    logic [15:0] host_addr = '0, host_wdata = '0, phy_rdata = '0;
    logic [15:0] host_rdata, phy_addr, phy_wdata;
    logic phy_req, phy_we;
    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    phy_ind_bridge i_phy_ind_bridge (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .phy_req(phy_req),
        .phy_we(phy_we), .phy_addr(phy_addr), .phy_wdata(phy_wdata),
        .phy_ack(phy_ack), .phy_rdata(phy_rdata)
    );

    // Expected-value helpers from the requirements (default PHY_MASK 0x3F).
    function automatic bit exp_present(input logic [3:0] f);
        return (f >= 1) && (f <= 6);
    endfunction
    function automatic logic [15:0] ind_addr(input logic [3:0] f, input logic [4:0] r);
        return {f, 12'h100 + {5'd0, r, 2'b00}};
    endfunction
    function automatic logic [15:0] phy_model(input logic [15:0] a);
        return a ^ 16'hA5C3;
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask
    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk); host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk); host_wr = 1'b0;
    endtask
    task automatic rd(input logic [15:0] a, output logic [15:0] d);
        @(negedge clk); host_addr = a; #1; d = host_rdata;
    endtask
    task automatic ack(input logic [15:0] d);
        @(negedge clk); phy_ack = 1'b1; phy_rdata = d;
        @(negedge clk); phy_ack = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v, a;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(IA, v); chk("R1 addr", v, 0);
        rd(ID, v); chk("R1 data", v, 0);
        rd(IC, v); chk("R1 ctrl", v, 0);
        rd(SP, v); chk("R1 spec", v, 0);
        rd(GC, v); chk("R1 gctrl", v, 0);
        chk("R1 req", {15'd0, phy_req}, 0);
        // R2 register map and kept bits
        wr(SP, 16'hFFFF); rd(SP, v); chk("R2 spec keep", v, 16'hF300);
        wr(GC, 16'hFFFF); rd(GC, v); chk("R2 gctrl keep", v, 16'h0080);
        wr(IA, 16'h1234); rd(IA, v); chk("R2 addr", v, 16'h1234);
        wr(ID, 16'hBEEF); rd(ID, v); chk("R2 data", v, 16'hBEEF);
        rd(16'h0760 + 16'd2, v); chk("R2 unmapped", v, 0);
        // R3 gating: block bit set, then enable clear
        wr(IA, ind_addr(4'd1, 5'd2));
        wr(IC, 16'h0001); chk("R3 block bit", {15'd0, phy_req}, 0);
        rd(IC, v); chk("R3 block ctrl", v, 0);
        wr(GC, 16'h0000); wr(SP, 16'h0000);
        wr(IC, 16'h0003); chk("R3 enable clear", {15'd0, phy_req}, 0);
        wr(SP, 16'h1000);
        // R4 write to port 0
        a = ind_addr(4'd1, 5'd3);
        wr(IA, a); wr(ID, 16'h5A5A); wr(IC, 16'h0003);
        chk("R4 req", {15'd0, phy_req}, 1);
        chk("R4 we", {15'd0, phy_we}, 1);
        chk("R4 addr", phy_addr, a);
        chk("R4 wdata", phy_wdata, 16'h5A5A);
        repeat (3) @(negedge clk);
        chk("R4 req held", {15'd0, phy_req}, 1);
        ack(16'h0000);
        rd(IC, v); chk("R4 ctrl done", v, 16'h0002);
        // R5 read from last present port (field 6)
        a = ind_addr(4'd6, 5'd31);
        wr(IA, a); wr(IC, 16'h0001);
        chk("R5 we", {15'd0, phy_we}, 0);
        rd(IC, v); chk("R5 busy", v, 16'h0001);
        ack(phy_model(a));
        rd(ID, v); chk("R5 data", v, phy_model(a));
        // R6 absent reads: fields 0, 7, 9
        foreach (a[i]) if (i < 3) begin
            logic [3:0] f;
            f = (i == 0) ? 4'd0 : (i == 1) ? 4'd7 : 4'd9;
            wr(ID, 16'h1111); wr(IA, ind_addr(f, 5'd1)); wr(IC, 16'h0001);
            chk("R6 no req", {15'd0, phy_req}, 0);
            rd(ID, v); chk("R6 ones", v, 16'hFFFF);
            rd(IC, v); chk("R6 ctrl", v, 0);
        end
        // R7 absent write, R10 error cleared by next start
        wr(ID, 16'h2222); wr(IA, ind_addr(4'd8, 5'd0)); wr(IC, 16'h0003);
        chk("R7 no req", {15'd0, phy_req}, 0);
        rd(IC, v); chk("R7 ctrl", v, 16'h8002);
        rd(ID, v); chk("R7 data kept", v, 16'h2222);
        wr(IA, ind_addr(4'd2, 5'd0)); wr(IC, 16'h0001);
        rd(IC, v); chk("R10 err cleared", v, 16'h0001);
        // R8 writes ignored while busy
        wr(IA, 16'hFFFF); wr(ID, 16'h7777); wr(IC, 16'h0000);
        rd(IA, v); chk("R8 addr locked", v, ind_addr(4'd2, 5'd0));
        rd(IC, v); chk("R8 ctrl locked", v, 16'h0001);
        ack(16'h0F0F);
        rd(ID, v); chk("R8 read result", v, 16'h0F0F);
        // R9 timeout on a read
        wr(IA, ind_addr(4'd3, 5'd4)); wr(IC, 16'h0001);
        repeat (TMO - 2) @(negedge clk);
        rd(IC, v); chk("R9 still busy", v, 16'h0001);
        rd(IC, v); chk("R9 aborted", v, 16'h8000);
        rd(ID, v); chk("R9 ones", v, 16'hFFFF);
        // R11 stray acknowledge
        wr(ID, 16'h3C3C); ack(16'h0000);
        rd(ID, v); chk("R11 data", v, 16'h3C3C);
        rd(IC, v); chk("R11 ctrl", v, 16'h8000);
        // Random rounds (R4 R5 R6 R7)
        for (int n = 0; n < 40; n++) begin
            logic [3:0] f; logic [4:0] r; logic we; logic [15:0] wd;
            f = 4'($urandom % 16); r = 5'($urandom % 32);
            we = 1'($urandom % 2); wd = 16'($urandom);
            a = ind_addr(f, r);
            wr(IA, a); wr(ID, wd); wr(IC, {14'd0, we, 1'b1});
            if (exp_present(f)) begin
                chk("R4 rnd req", {15'd0, phy_req}, 1);
                chk("R4 rnd addr", phy_addr, a);
                chk("R4 rnd we", {15'd0, phy_we}, {15'd0, we});
                repeat ($urandom % 6) @(negedge clk);
                ack(phy_model(a));
                rd(IC, v); chk("R4 rnd ctrl", v, {14'd0, we, 1'b0});
                rd(ID, v); chk("R5 rnd data", v, we ? wd : phy_model(a));
            end else begin
                chk("R6 rnd no req", {15'd0, phy_req}, 0);
                rd(IC, v); chk("R7 rnd ctrl", v, we ? 16'h8002 : 16'h0000);
                rd(ID, v); chk("R6 rnd data", v, we ? wd : 16'hFFFF);
            end
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule